// File: doc/BRIEF.md
# Parallel Configuration Loader and Readback Filter

This block drives the serial configuration ports of a row of logic chips, all of them at once, and later pulls their state back out. While loading, each host word is split by bit position: lane i of the word becomes the next serial bit for chip i. The result is that every chip shifts one bit on the same pulse, and a full configuration of `STREAM_BITS` bits takes `STREAM_BITS` host words.

For readback, the block clocks every chip's serial readback stream one bit per cycle. Most positions in that stream are configuration bits and are of no interest to the host. The block keeps only the positions that hold user flip-flop state and packs the bits taken from all chips at one kept position into a single output word. A keep-mask function of the bit index selects the positions. With the default settings, one position in every `KEEP_STRIDE` is kept. Readback never drives the configuration pins, so the chips can carry on running once it is finished.

Both operations are started by a one-cycle request. A request that arrives while an operation is running is ignored, and `busy` shows when the block is occupied.

Top module: `cfg_stream_loader`

## Requirements
- R1: While reset is held, `busy`, `wordReady`, `rbShift`, `cfgShift`, `loadDone`, `readDone` and `outValid` are all 0.
- R2: `loadStart` seen in an idle cycle makes `busy` and `wordReady` high from the next cycle until the load completes.
- R3: Each cycle with `wordValid` and `wordReady` both high accepts one word. The next cycle then carries exactly one `cfgShift` pulse, with `cfgData` equal to that word. Bit i goes to chip lane i.
- R4: The load completes on the `STREAM_BITS`-th accepted word. `loadDone` pulses for one cycle, together with the final `cfgShift`, and `busy` falls in that same cycle.
- R5: `wordValid` has no effect when no load is running: `cfgShift` stays 0.
- R6: `readStart` seen in an idle cycle (with `loadStart` low) starts a readback. `rbShift` is then high for exactly `STREAM_BITS` consecutive cycles, and `readDone` pulses in the cycle after the last one.
- R7: Bit index k of the readback stream counts from 0 at the first `rbShift` cycle. Index k is kept when k mod `KEEP_STRIDE` equals `KEEP_STRIDE`-1. For a kept index, `outValid` pulses in the next cycle and `outData` equals the `rbData` sampled at index k. An index that is not kept produces no output. A readback therefore yields `STREAM_BITS`/`KEEP_STRIDE` words.
- R8: Readback is nondestructive. No `cfgShift` occurs during a readback, so a second readback returns the same words as the first.
- R9: `loadStart` or `readStart` seen while `busy` is high is ignored. The running operation continues without change.
- R10: When `loadStart` and `readStart` arrive together in an idle cycle, the load is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadStart | input | 1 | Request to begin a configuration load |
| readStart | input | 1 | Request to begin a filtered readback |
| wordValid | input | 1 | Host word present on `wordData` |
| wordData | input | LANES | Host configuration word, bit i for chip i |
| wordReady | output | 1 | A load is running and words are accepted |
| cfgData | output | LANES | Serial configuration bit per chip |
| cfgShift | output | 1 | Shift pulse for the configuration bits |
| loadDone | output | 1 | One-cycle pulse when the load completes |
| rbData | input | LANES | Current readback bit from each chip |
| rbShift | output | 1 | Readback advance for all chips |
| outValid | output | 1 | Kept readback word present on `outData` |
| outData | output | LANES | Packed kept bits, bit i from chip i |
| readDone | output | 1 | One-cycle pulse when the readback completes |
| busy | output | 1 | A load or readback is running |

## Verification
Two things can land in the same cycle: a start request arriving while the other operation is running, and the two start requests arriving together in an idle cycle. The bench pulses `readStart` and `loadStart` in the middle of a load. It also pulses `loadStart` and `wordValid` in the middle of a readback. The timing of every output is then judged against a behavioural model that is stepped on every clock. The simultaneous request is raised once from idle. The bench checks that loading begins, and that the chip contents and the filtered words of two back-to-back readbacks stay consistent with that outcome.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_READ = 2'd2
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrCnt;
    logic acceptWord;
    logic sampleBit;
  } dpStrobe_t;

  // keep-mask lookup: one position out of every stride holds user state
  function automatic logic keepLookup(input int unsigned idx, input int unsigned stride);
    return (idx % stride) == (stride - 1);
  endfunction

endpackage

// File: rtl/cfgl_ctrl.sv
module cfgl_ctrl
  import cfgl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadStart,
  input  logic      readStart,
  input  logic      wordValid,
  input  logic      cntLast,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      wordReady,
  output logic      rbShift,
  output logic      loadDone,
  output logic      readDone
);

  seqState_t state, stateNext;

  always_comb begin
    strobe.clrCnt     = (state == ST_IDLE);
    strobe.acceptWord = (state == ST_LOAD) && wordValid;
    strobe.sampleBit  = (state == ST_READ);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (loadStart)      stateNext = ST_LOAD;   // load wins a tie
        else if (readStart) stateNext = ST_READ;
      end
      ST_LOAD: if (strobe.acceptWord && cntLast) stateNext = ST_IDLE;
      ST_READ: if (cntLast)                      stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      loadDone <= 1'b0;
      readDone <= 1'b0;
    end else begin
      state    <= stateNext;
      loadDone <= strobe.acceptWord && cntLast;
      readDone <= strobe.sampleBit && cntLast;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign wordReady = (state == ST_LOAD);
  assign rbShift   = (state == ST_READ);

  // R2: a load request from idle opens the word window
  p_load_opens_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && loadStart) |=> wordReady);

  // R9: start requests during a running load leave it running
  p_busy_load_kept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && (loadStart || readStart) && !(strobe.acceptWord && cntLast))
      |=> (state == ST_LOAD));

  // R9: start requests during a running readback leave it running
  p_busy_read_kept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && (loadStart || readStart) && !cntLast) |=> (state == ST_READ));

  // R4: completion pulses never overlap
  p_one_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadDone, readDone}));

endmodule

// File: rtl/cfgl_datapath.sv
module cfgl_datapath
  import cfgl_pkg::*;
#(
  parameter int LANES       = 32,
  parameter int STREAM_BITS = 4096,
  parameter int KEEP_STRIDE = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [LANES-1:0] wordData,
  input  logic [LANES-1:0] rbData,
  output logic             cntLast,
  output logic [LANES-1:0] cfgData,
  output logic             cfgShift,
  output logic [LANES-1:0] outData,
  output logic             outValid
);

  localparam int CNT_W = (STREAM_BITS > 2) ? $clog2(STREAM_BITS) : 1;

  logic [CNT_W-1:0] bitCnt;
  logic             keepHit;
  logic             keepCapture;

  assign cntLast     = (bitCnt == CNT_W'(STREAM_BITS - 1));
  assign keepHit     = keepLookup(32'(bitCnt), KEEP_STRIDE);
  assign keepCapture = strobe.sampleBit && keepHit;

  // one bit counter serves all chips: they shift in lockstep
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrCnt)
      bitCnt <= '0;
    else if (strobe.acceptWord || strobe.sampleBit)
      bitCnt <= cntLast ? '0 : bitCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgShift <= 1'b0;
      outValid <= 1'b0;
    end else begin
      cfgShift <= strobe.acceptWord;
      outValid <= keepCapture;
    end
  end

  // per-chip lane registers
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgData[lane] <= 1'b0;
        outData[lane] <= 1'b0;
      end else begin
        if (strobe.acceptWord) cfgData[lane] <= wordData[lane];
        if (keepCapture)       outData[lane] <= rbData[lane];
      end
    end
  end

  // R3: an accepted word shows up on the serial lanes next cycle
  p_word_to_lanes_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.acceptWord |=> (cfgShift && cfgData == $past(wordData)));

  // R7: output only follows a readback sample
  p_valid_after_sample_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strobe.sampleBit));

endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfgl_pkg::*;
#(
  parameter int LANES       = 32,
  parameter int STREAM_BITS = 4096,
  parameter int KEEP_STRIDE = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadStart,
  input  logic             readStart,
  input  logic             wordValid,
  input  logic [LANES-1:0] wordData,
  output logic             wordReady,
  output logic [LANES-1:0] cfgData,
  output logic             cfgShift,
  output logic             loadDone,
  input  logic [LANES-1:0] rbData,
  output logic             rbShift,
  output logic             outValid,
  output logic [LANES-1:0] outData,
  output logic             readDone,
  output logic             busy
);

  dpStrobe_t strobe;
  logic      cntLast;

  cfgl_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadStart (loadStart),
    .readStart (readStart),
    .wordValid (wordValid),
    .cntLast   (cntLast),
    .strobe    (strobe),
    .busy      (busy),
    .wordReady (wordReady),
    .rbShift   (rbShift),
    .loadDone  (loadDone),
    .readDone  (readDone)
  );

  cfgl_datapath #(
    .LANES       (LANES),
    .STREAM_BITS (STREAM_BITS),
    .KEEP_STRIDE (KEEP_STRIDE)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wordData (wordData),
    .rbData   (rbData),
    .cntLast  (cntLast),
    .cfgData  (cfgData),
    .cfgShift (cfgShift),
    .outData  (outData),
    .outValid (outValid)
  );

  // R8: readback cycles never produce a configuration shift
  p_no_cfg_in_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    rbShift |=> !cfgShift);

  // R6: load window and readback clocking are exclusive
  p_exclusive_ops_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(wordReady && rbShift));

  // R4: completion coincides with the final shift
  p_done_with_shift_r4: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> (cfgShift && !busy));

  // R5: words offered outside a load are dropped
  p_idle_word_dropped_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !wordReady) |=> !cfgShift);

  // R10: simultaneous requests from idle start the load
  p_tie_goes_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && loadStart && readStart) |=> (wordReady && !rbShift));

endmodule

// File: tb/test_cfg_stream_loader.sv
`timescale 1ns/1ps
module test_cfg_stream_loader;

  localparam int LANES = 32;
  localparam int SB    = 256;
  localparam int KS    = 16;
  localparam int KB    = SB / KS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadStart = 1'b0, readStart = 1'b0, wordValid = 1'b0;
  logic [LANES-1:0] wordData = '0;
  logic [LANES-1:0] rbData;
  logic wordReady, cfgShift, loadDone, rbShift, outValid, readDone, busy;
  logic [LANES-1:0] cfgData, outData;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  cfg_stream_loader #(.LANES(LANES), .STREAM_BITS(SB), .KEEP_STRIDE(KS)) i_cfg_stream_loader (
    .clk(clk), .rstN(rstN), .loadStart(loadStart), .readStart(readStart),
    .wordValid(wordValid), .wordData(wordData), .wordReady(wordReady),
    .cfgData(cfgData), .cfgShift(cfgShift), .loadDone(loadDone),
    .rbData(rbData), .rbShift(rbShift), .outValid(outValid), .outData(outData),
    .readDone(readDone), .busy(busy)
  );

  // chip array model: one stored stream word per bit index, lane i = chip i
  logic [LANES-1:0] chipMem [SB];
  int wPtr = 0;
  int rPtr = 0;
  always @(posedge clk) begin
    if (cfgShift) begin
      chipMem[wPtr] <= cfgData;
      wPtr <= (wPtr == SB - 1) ? 0 : wPtr + 1;
    end
    if (rbShift) rPtr <= (rPtr == SB - 1) ? 0 : rPtr + 1;
  end
  assign rbData = chipMem[rPtr];

  // behavioural reference
  int mode = 0;   // 0 idle, 1 loading, 2 reading
  int cnt = 0;
  bit expShift, expLoadDone, expReadDone, expValid;
  logic [LANES-1:0] expCfg;
  logic [LANES-1:0] refWords [SB];
  logic [LANES-1:0] expQ [$];
  logic [LANES-1:0] gotQ [$];

  always @(posedge clk) begin
    expShift = 0; expLoadDone = 0; expReadDone = 0; expValid = 0;
    if (!rstN) begin
      mode = 0; cnt = 0;
    end else begin
      case (mode)
        0: begin
          if (loadStart) begin mode = 1; cnt = 0; end
          else if (readStart) begin mode = 2; cnt = 0; end
        end
        1: if (wordValid) begin
          expShift = 1; expCfg = wordData; refWords[cnt] = wordData;
          if (cnt == SB - 1) begin expLoadDone = 1; mode = 0; end
          else cnt++;
        end
        default: begin
          if ((cnt % KS) == KS - 1) begin expValid = 1; expQ.push_back(refWords[cnt]); end
          if (cnt == SB - 1) begin expReadDone = 1; mode = 0; end
          else cnt++;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [LANES-1:0] act,
                     input logic [LANES-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      chk({busy, wordReady, rbShift, cfgShift, loadDone, readDone, outValid} == '0,
          "R1 reset outputs", 32'({busy, wordReady, rbShift, cfgShift, loadDone, readDone, outValid}), '0);
    end else begin
      chk(busy == (mode != 0), "R2/R9 busy", 32'(busy), 32'(mode != 0));
      chk(wordReady == (mode == 1), "R2/R10 wordReady", 32'(wordReady), 32'(mode == 1));
      chk(rbShift == (mode == 2), "R6 rbShift", 32'(rbShift), 32'(mode == 2));
      chk(cfgShift == expShift, "R3/R5/R8 cfgShift", 32'(cfgShift), 32'(expShift));
      if (expShift) chk(cfgData == expCfg, "R3 cfgData", cfgData, expCfg);
      chk(loadDone == expLoadDone, "R4 loadDone", 32'(loadDone), 32'(expLoadDone));
      chk(readDone == expReadDone, "R6 readDone", 32'(readDone), 32'(expReadDone));
      chk(outValid == expValid, "R7 outValid", 32'(outValid), 32'(expValid));
      if (outValid) begin
        logic [LANES-1:0] e;
        e = (expQ.size() > 0) ? expQ.pop_front() : 'x;
        chk(outData === e, "R7 outData", outData, e);
        gotQ.push_back(outData);
      end
    end
  end

  function automatic logic [LANES-1:0] genWord(input int seed, input int w);
    return 32'(seed) ^ (32'(w) * 32'h9E3779B1) ^ (32'(w) << 16);
  endfunction

  task automatic runLoad(input int seed, input bit withTie, input bit poke);
    int sent = 0;
    int cyc = 0;
    @(negedge clk);
    loadStart = 1'b1;
    readStart = withTie;
    @(negedge clk);
    loadStart = 1'b0; readStart = 1'b0;
    while (sent < SB) begin
      cyc++;
      if (poke && cyc == 12) begin loadStart = 1'b1; readStart = 1'b1; end  // R9
      else begin loadStart = 1'b0; readStart = 1'b0; end
      if (cyc % 5 == 2) wordValid = 1'b0;
      else begin wordValid = 1'b1; wordData = genWord(seed, sent); sent++; end
      @(negedge clk);
    end
    wordValid = 1'b0; loadStart = 1'b0; readStart = 1'b0;
    repeat (3) @(negedge clk);
    // R3: every lane of every index reached its chip
    for (int k = 0; k < SB; k++)
      chk(chipMem[k] == genWord(seed, k), "R3 chip lane contents", chipMem[k], genWord(seed, k));
  endtask

  task automatic runRead(input bit poke);
    int cyc = 0;
    gotQ.delete();
    @(negedge clk);
    readStart = 1'b1;
    @(negedge clk);
    readStart = 1'b0;
    while (busy) begin
      cyc++;
      if (poke && (cyc % 7 == 3)) begin loadStart = 1'b1; wordValid = 1'b1; wordData = 32'hDEAD_BEEF; end
      else begin loadStart = 1'b0; wordValid = 1'b0; end
      @(negedge clk);
    end
    loadStart = 1'b0; wordValid = 1'b0;
    repeat (3) @(negedge clk);
    chk(gotQ.size() == KB, "R7 kept word count", 32'(gotQ.size()), 32'(KB));
  endtask

  logic [LANES-1:0] firstRun [$];

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R5: words offered in idle are dropped
    wordValid = 1'b1; wordData = 32'h1234_5678;
    repeat (4) @(negedge clk);
    wordValid = 1'b0;
    chk(wPtr == 0, "R5 no idle shift", 32'(wPtr), 0);
    // R10 tie, R9 pokes during the load
    runLoad(32'h5A5A_0001, 1'b1, 1'b1);
    // R8 pokes during readback, then a clean repeat readback
    runRead(1'b1);
    firstRun = gotQ;
    runRead(1'b0);
    for (int k = 0; k < KB; k++)
      chk(gotQ[k] == firstRun[k], "R8 repeat readback identical", gotQ[k], firstRun[k]);
    // second load with fresh data, then readback
    runLoad(32'hC3C3_7777, 1'b0, 1'b0);
    runRead(1'b0);
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule